// File: doc/BRIEF.md
# Priority-Packed Peripheral Pin Router

This block sits between a small set of on-chip peripherals and a row of general-purpose pins. Software enables peripherals through three small configuration registers. The router then packs each enabled peripheral onto the lowest free pins, working down a fixed priority list. Pins that no peripheral claims stay under the control of the ordinary port latch and its direction bits.

The priority list, from highest to lowest, is:
1. The two-wire serial port (transmit, then receive).
2. The serial peripheral interface, on SCK, MISO, MOSI and the optional slave select.
3. External interrupt input A.
4. External interrupt input B.

Because positions are packed, turning one peripheral on or off moves every peripheral below it. The SPI takes a slave-select pin only in four-wire mode. That mode is captured at the moment the router is switched on, so it must be settled beforehand.

Each peripheral signal also has a reported pin index and a valid bit. With these, surrounding logic or a bench can see where a signal landed without reproducing the packing. All outputs are registered, so every output follows its inputs and configuration one clock later.

Top module: `pin_xbar`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every pin output enable is 0, every pin output is 0, no signal is valid and overflow is 0.
- R2: While the global enable is clear (write select 2, data bit 6), no signal is valid and overflow is 0. Every pin then shows `port_latch` on `pin_out` and `gp_oe` on `pin_oe`.
- R3: The router places groups in this priority order, each one starting at the lowest free pin from pin 0 upward:
  - Serial port: write select 0, bit 2. Transmit, then receive.
  - SPI: write select 0, bit 1. SCK, MISO, MOSI, then NSS.
  - Interrupt A: write select 1, bit 2.
  - Interrupt B: write select 1, bit 4.

  Signal indices 0..7 are TX, RX, SCK, MISO, MOSI, NSS, INTA and INTB. Signal s reports its pin in `sig_pin[s*PW +: PW]`, with PW = 6 for 32 pins.
- R4: With the serial port off and the SPI on in four-wire mode, SCK, MISO, MOSI and NSS occupy pins 0, 1, 2 and 3.
- R5: In three-wire mode, NSS is not valid and takes no pin. The next group starts directly after MOSI.
- R6: The SPI mode is sampled from `spi_four_wire` on the clock edge that writes the global enable from 0 to 1. Later changes to that input, and rewrites of the enable while it is already set, do not change the mapping.
- R7: On a claimed pin, `pin_out` follows the owning peripheral's output and ignores `port_latch`.
- R8: Output enables on claimed pins follow the signal type:
  - TX is always driven (1).
  - RX and both interrupt inputs are never driven (0).
  - Each SPI signal uses its own bit of `periph_oe`.
- R9: `periph_in[s]` carries the input of the pin assigned to signal s. A signal without a pin reads 0.
- R10: A group that does not fit in the remaining pins gets no pin, and `overflow` is raised. Later groups that still fit are placed after the pins already in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 enables A, 1 enables B, 2 global) |
| cfg_wdata | input | 8 | Configuration write data |
| spi_four_wire | input | 1 | SPI mode from the peripheral, 1 = four-wire |
| port_latch | input | NUM_PINS | General-purpose output latch |
| gp_oe | input | NUM_PINS | General-purpose output enables |
| pin_in | input | NUM_PINS | Values read from the pins |
| pin_out | output | NUM_PINS | Value driven to each pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| periph_out | input | 8 | Peripheral output per signal |
| periph_oe | input | 8 | Peripheral output enable per signal |
| periph_in | output | 8 | Pin value returned to each signal |
| sig_pin | output | 8*PW | Assigned pin index per signal |
| sig_valid | output | 8 | Signal has a pin |
| overflow | output | 1 | An enabled group did not fit |

## Verification
The mode capture and the global enable can fall on the same edge. The bench changes `spi_four_wire` in the very cycle that writes the enable from 0 to 1, and expects the new value to be the one taken. Pin ownership and the port latch also meet on one pin. The bench raises every latch bit while the serial transmitter holds its pin low, and judges the pin by whether it follows the peripheral or the latch. A second, narrow instance of four pins forces a group that does not fit, while smaller groups below it still do.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NSIG    = 8;
  localparam int NGRP    = 4;
  localparam int MAX_GRP = 4;

  localparam int SIG_TX   = 0;
  localparam int SIG_RX   = 1;
  localparam int SIG_SCK  = 2;
  localparam int SIG_MISO = 3;
  localparam int SIG_MOSI = 4;
  localparam int SIG_NSS  = 5;
  localparam int SIG_INTA = 6;
  localparam int SIG_INTB = 7;

  typedef enum logic [1:0] {DIR_IN, DIR_OUT, DIR_PERIPH} sig_dir_e;

  function automatic sig_dir_e sig_dir(int s);
    case (s)
      SIG_TX:                     return DIR_OUT;
      SIG_RX, SIG_INTA, SIG_INTB: return DIR_IN;
      default:                    return DIR_PERIPH;
    endcase
  endfunction

  // first signal index of each priority group
  function automatic int grp_first(int g);
    case (g)
      0:       return SIG_TX;
      1:       return SIG_SCK;
      2:       return SIG_INTA;
      default: return SIG_INTB;
    endcase
  endfunction

  // pins a group needs; SPI drops slave select in three-wire mode
  function automatic int grp_size(int g, logic four_wire);
    case (g)
      0:       return 2;
      1:       return four_wire ? 4 : 3;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/pin_xbar_cfg.sv
module pin_xbar_cfg
  import pin_xbar_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic            spi_four_wire,
  output logic [NGRP-1:0] grp_en,
  output logic            xbar_on,
  output logic            four_wire_q
);
  logic uart_en, spi_en, inta_en, intb_en, on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      uart_en     <= 1'b0;
      spi_en      <= 1'b0;
      inta_en     <= 1'b0;
      intb_en     <= 1'b0;
      on_q        <= 1'b0;
      four_wire_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin
          spi_en  <= cfg_wdata[1];
          uart_en <= cfg_wdata[2];
        end
        2'd1: begin
          inta_en <= cfg_wdata[2];
          intb_en <= cfg_wdata[4];
        end
        2'd2: begin
          on_q <= cfg_wdata[6];
          // mode is frozen only on the off-to-on transition
          if (cfg_wdata[6] && !on_q) four_wire_q <= spi_four_wire;
        end
        default: ;
      endcase
    end
  end

  assign grp_en  = {intb_en, inta_en, spi_en, uart_en};
  assign xbar_on = on_q;
endmodule

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PW       = 6
) (
  input  logic                     xbar_on,
  input  logic [NGRP-1:0]          grp_en,
  input  logic                     four_wire,
  output logic [NSIG-1:0][PW-1:0]  sig_idx,
  output logic [NSIG-1:0]          sig_ok,
  output logic                     ovf
);
  always_comb begin
    int nxt;
    int sz;
    sig_idx = '0;
    sig_ok  = '0;
    ovf     = 1'b0;
    nxt     = 0;
    for (int g = 0; g < NGRP; g++) begin
      sz = grp_size(g, four_wire);
      if (xbar_on && grp_en[g]) begin
        if (nxt + sz <= NUM_PINS) begin
          for (int k = 0; k < MAX_GRP; k++) begin
            if (k < sz) begin
              sig_idx[grp_first(g) + k] = PW'(nxt + k);
              sig_ok[grp_first(g) + k]  = 1'b1;
            end
          end
          nxt = nxt + sz;
        end else begin
          ovf = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pin_xbar_mux.sv
module pin_xbar_mux
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PW       = 6
) (
  input  logic [NSIG-1:0][PW-1:0] sig_idx,
  input  logic [NSIG-1:0]         sig_ok,
  input  logic [NSIG-1:0]         periph_out,
  input  logic [NSIG-1:0]         periph_oe,
  input  logic [NUM_PINS-1:0]     port_latch,
  input  logic [NUM_PINS-1:0]     gp_oe,
  input  logic [NUM_PINS-1:0]     pin_in,
  output logic [NUM_PINS-1:0]     pin_out_c,
  output logic [NUM_PINS-1:0]     pin_oe_c,
  output logic [NSIG-1:0]         periph_in_c
);
  logic [NSIG-1:0] oe_eff;

  for (genvar s = 0; s < NSIG; s++) begin : g_dir
    if (sig_dir(s) == DIR_OUT) begin : g_out
      assign oe_eff[s] = 1'b1;
    end else if (sig_dir(s) == DIR_IN) begin : g_in
      assign oe_eff[s] = 1'b0;
    end else begin : g_per
      assign oe_eff[s] = periph_oe[s];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit, o_v, e_v;
    always_comb begin
      hit = 1'b0;
      o_v = 1'b0;
      e_v = 1'b0;
      for (int s = 0; s < NSIG; s++) begin
        if (sig_ok[s] && sig_idx[s] == PW'(p)) begin
          hit = 1'b1;
          o_v = periph_out[s];
          e_v = oe_eff[s];
        end
      end
    end
    assign pin_out_c[p] = hit ? o_v : port_latch[p];
    assign pin_oe_c[p]  = hit ? e_v : gp_oe[p];
  end

  always_comb begin
    periph_in_c = '0;
    for (int s = 0; s < NSIG; s++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (sig_ok[s] && sig_idx[s] == PW'(p)) periph_in_c[s] = pin_in[p];
      end
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PW       = $clog2(NUM_PINS) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [7:0]           cfg_wdata,
  input  logic                 spi_four_wire,
  input  logic [NUM_PINS-1:0]  port_latch,
  input  logic [NUM_PINS-1:0]  gp_oe,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  input  logic [NSIG-1:0]      periph_out,
  input  logic [NSIG-1:0]      periph_oe,
  output logic [NSIG-1:0]      periph_in,
  output logic [NSIG*PW-1:0]   sig_pin,
  output logic [NSIG-1:0]      sig_valid,
  output logic                 overflow
);
  logic [NGRP-1:0]         grp_en;
  logic                    xbar_on;
  logic                    four_wire_q;
  logic [NSIG-1:0][PW-1:0] sig_idx;
  logic [NSIG-1:0]         sig_ok;
  logic                    ovf_c;
  logic [NUM_PINS-1:0]     pin_out_c, pin_oe_c;
  logic [NSIG-1:0]         periph_in_c;

  pin_xbar_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .spi_four_wire(spi_four_wire),
    .grp_en(grp_en), .xbar_on(xbar_on), .four_wire_q(four_wire_q)
  );

  pin_xbar_alloc #(.NUM_PINS(NUM_PINS), .PW(PW)) u_alloc (
    .xbar_on(xbar_on), .grp_en(grp_en), .four_wire(four_wire_q),
    .sig_idx(sig_idx), .sig_ok(sig_ok), .ovf(ovf_c)
  );

  pin_xbar_mux #(.NUM_PINS(NUM_PINS), .PW(PW)) u_mux (
    .sig_idx(sig_idx), .sig_ok(sig_ok), .periph_out(periph_out),
    .periph_oe(periph_oe), .port_latch(port_latch), .gp_oe(gp_oe),
    .pin_in(pin_in), .pin_out_c(pin_out_c), .pin_oe_c(pin_oe_c),
    .periph_in_c(periph_in_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out   <= '0;
      pin_oe    <= '0;
      periph_in <= '0;
      sig_pin   <= '0;
      sig_valid <= '0;
      overflow  <= 1'b0;
    end else begin
      pin_out   <= pin_out_c;
      pin_oe    <= pin_oe_c;
      periph_in <= periph_in_c;
      sig_pin   <= sig_idx;
      sig_valid <= sig_ok;
      overflow  <= ovf_c;
    end
  end
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PW       = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                xbar_on,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NSIG-1:0]     periph_out,
  input logic [NSIG-1:0]     periph_in,
  input logic [NSIG*PW-1:0]  sig_pin,
  input logic [NSIG-1:0]     sig_valid,
  input logic                overflow
);
  logic [NUM_PINS-1:0] pin_in_d;
  logic [PW-1:0] tx_idx, rx_idx, sck_idx;

  always_ff @(posedge clk) pin_in_d <= pin_in;

  assign tx_idx  = sig_pin[SIG_TX*PW +: PW];
  assign rx_idx  = sig_pin[SIG_RX*PW +: PW];
  assign sck_idx = sig_pin[SIG_SCK*PW +: PW];

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && sig_valid == '0 && !overflow));

  p_off_no_owner_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(xbar_on) |-> (sig_valid == '0 && !overflow));

  p_order_r3: assert property (@(posedge clk) disable iff (rst)
    (sig_valid[SIG_TX] && sig_valid[SIG_SCK]) |-> (sck_idx > tx_idx));

  p_claim_out_r7: assert property (@(posedge clk) disable iff (rst)
    sig_valid[SIG_TX] |-> (pin_out[tx_idx] == $past(periph_out[SIG_TX])));

  p_input_only_r8: assert property (@(posedge clk) disable iff (rst)
    sig_valid[SIG_RX] |-> !pin_oe[rx_idx]);

  p_forward_r9: assert property (@(posedge clk) disable iff (rst)
    sig_valid[SIG_RX] |-> (periph_in[SIG_RX] == pin_in_d[rx_idx]));
endmodule

bind pin_xbar pin_xbar_chk #(.NUM_PINS(NUM_PINS), .PW(PW)) u_chk (.*);

// File: tb/pin_xbar_test.sv
module pin_xbar_test;
  localparam int NP = 32;
  localparam int PW = 6;
  localparam int SP = 4;
  localparam int SW = 3;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic spi_four_wire = 0;
  logic [NP-1:0] port_latch = 0, gp_oe = 0, pin_in = 0, pin_out, pin_oe;
  logic [7:0] periph_out = 0, periph_oe = 0, periph_in, sig_valid;
  logic [8*PW-1:0] sig_pin;
  logic overflow;

  logic [SP-1:0] s_latch = 0, s_goe = 0, s_in = 0, s_out, s_oe;
  logic [7:0] s_pin_p, s_valid;
  logic [8*SW-1:0] s_sig_pin;
  logic s_ovf;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  pin_xbar #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .spi_four_wire(spi_four_wire), .port_latch(port_latch), .gp_oe(gp_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .periph_out(periph_out),
    .periph_oe(periph_oe), .periph_in(periph_in), .sig_pin(sig_pin),
    .sig_valid(sig_valid), .overflow(overflow)
  );

  pin_xbar #(.NUM_PINS(SP)) uut_small (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .spi_four_wire(spi_four_wire), .port_latch(s_latch), .gp_oe(s_goe),
    .pin_in(s_in), .pin_out(s_out), .pin_oe(s_oe), .periph_out(periph_out),
    .periph_oe(periph_oe), .periph_in(s_pin_p), .sig_pin(s_sig_pin),
    .sig_valid(s_valid), .overflow(s_ovf)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [PW-1:0] pin_of(int s);
    return sig_pin[s*PW +: PW];
  endfunction

  task automatic t_reset();
    chk("R1", "pin_oe", pin_oe, 0);
    chk("R1", "pin_out", pin_out, 0);
    chk("R1", "sig_valid", sig_valid, 0);
    chk("R1", "overflow", overflow, 0);
  endtask

  task automatic t_off();
    wr(0, 8'h06); wr(1, 8'h14);
    port_latch = 32'hA5A5_0F0F; gp_oe = 32'hFFFF_0000;
    settle();
    chk("R2", "valid while off", sig_valid, 0);
    chk("R2", "pin_out latch", pin_out, 32'hA5A5_0F0F);
    chk("R2", "pin_oe gp", pin_oe, 32'hFFFF_0000);
    port_latch = 0; gp_oe = 0;
  endtask

  task automatic t_spi_only();
    spi_four_wire = 1;
    wr(0, 8'h02); wr(1, 8'h00); wr(2, 8'h40);
    settle();
    chk("R4", "valid", sig_valid, 8'b0011_1100);
    chk("R4", "sck", pin_of(2), 0);
    chk("R4", "miso", pin_of(3), 1);
    chk("R4", "mosi", pin_of(4), 2);
    chk("R4", "nss", pin_of(5), 3);
    wr(2, 8'h00);
  endtask

  task automatic t_all();
    spi_four_wire = 1;
    wr(0, 8'h06); wr(1, 8'h14); wr(2, 8'h40);
    settle();
    chk("R3", "valid", sig_valid, 8'hFF);
    for (int s = 0; s < 8; s++) chk("R3", $sformatf("pin of sig %0d", s), pin_of(s), s);
    chk("R10", "no overflow at 32 pins", overflow, 0);
  endtask

  task automatic t_latch();
    port_latch = 0; periph_out = 8'h01;
    settle();
    chk("R7", "tx high over latch 0", pin_out[0], 1);
    port_latch = '1; periph_out = 8'h00;
    settle();
    chk("R7", "tx low over latch 1", pin_out[0], 0);
    chk("R7", "free pin 8 follows latch", pin_out[8], 1);
    port_latch = 0;
  endtask

  task automatic t_oe();
    periph_oe = 8'hFF;
    settle();
    chk("R8", "oe all set", pin_oe[7:0], 8'b0011_1101);
    periph_oe = 8'h00;
    settle();
    chk("R8", "oe all clear", pin_oe[7:0], 8'b0000_0001);
  endtask

  task automatic t_in();
    pin_in = 32'h0000_0002; settle();
    chk("R9", "rx gets pin1", periph_in, 8'b0000_0010);
    pin_in = 32'h0000_0080; settle();
    chk("R9", "intb gets pin7", periph_in, 8'b1000_0000);
    pin_in = 32'h0000_0010; settle();
    chk("R9", "mosi gets pin4", periph_in, 8'b0001_0000);
    pin_in = 0;
  endtask

  task automatic t_three();
    wr(2, 8'h00);
    spi_four_wire = 0;
    wr(2, 8'h40);
    settle();
    chk("R5", "valid", sig_valid, 8'b1101_1111);
    chk("R5", "inta after mosi", pin_of(6), 5);
    chk("R5", "intb", pin_of(7), 6);
    pin_in = 32'h0000_0020; settle();
    chk("R9", "unmapped nss reads 0", periph_in[5], 0);
    pin_in = 0;
  endtask

  task automatic t_snapshot();
    wr(2, 8'h00);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2; cfg_wdata = 8'h40; spi_four_wire = 1;
    @(negedge clk);
    cfg_we = 0;
    settle();
    chk("R6", "same-edge mode taken", sig_valid[5], 1);
    spi_four_wire = 0; settle();
    chk("R6", "later mode change ignored", pin_of(6), 6);
    wr(2, 8'h40); settle();
    chk("R6", "rewrite while on ignored", sig_valid[5], 1);
    wr(2, 8'h00); wr(2, 8'h40); settle();
    chk("R6", "re-enable recaptures", pin_of(6), 5);
  endtask

  task automatic t_overflow();
    wr(2, 8'h00);
    spi_four_wire = 1;
    wr(2, 8'h40);
    settle();
    chk("R10", "small overflow", s_ovf, 1);
    chk("R10", "small valid", s_valid, 8'b1100_0011);
    chk("R10", "small inta", s_sig_pin[6*SW +: SW], 2);
    chk("R10", "small intb", s_sig_pin[7*SW +: SW], 3);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 0;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_off();
    t_spi_only();
    t_all();
    t_latch();
    t_oe();
    t_in();
    t_three();
    t_snapshot();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule